// File: doc/BRIEF.md
# Register-Mapped Factorial Accelerator

This peripheral sits behind a simple 32-bit register port and computes factorials in the background. Software writes an operand into the operand/result register. It then either polls a busy bit in the status word or waits for the interrupt line. When the work is done, it reads the answer back from the same register. One multiply is done per clock, with a counter running down from the operand, so a larger operand keeps the block busy for longer.

The block also holds three simpler registers. The first is a fixed identification word. The second is a liveness register that hands back the bitwise inverse of whatever was last written to it. The third is a 32-bit interrupt status word, which any source can set through an OR-set register and clear through a clear-by-mask register. A single level interrupt output is high while any status bit is set. Read data is registered and appears one cycle after the read request.

Top module: `fact_accel_top`

## Requirements
- R1: A 4-byte read of offset 0x00 returns 0x010000ED.
- R2: A 4-byte write to offset 0x04 stores the bitwise complement of the written data, and a read of 0x04 returns that stored complement.
- R3: A 4-byte write to offset 0x08 while idle loads the operand and sets status bit 0 (busy); a write to 0x08 while busy has no effect on the operand or the result.
- R4: After completion, offset 0x08 reads n! modulo 2^32 (operands 0 and 1 give 1) and busy is clear; busy stays set for max(n,1) clock edges after the loading edge.
- R5: Offset 0x20 reads busy in bit 0, completion-interrupt enable in bit 7, and zeros elsewhere; writes to 0x20 change only bit 7.
- R6: On completion with the enable bit set, bit 0 of the interrupt status (offset 0x24) is set; with the enable bit clear, completion leaves the interrupt status unchanged.
- R7: A write to 0x60 ORs the data into the interrupt status and a write to 0x64 clears the bits set in the data; when a set and a clear of the same bit land in the same cycle, the set wins.
- R8: The interrupt output is high exactly when the interrupt status is nonzero.
- R9: Any access whose size is not 4 bytes is ignored, and such a read returns 0xFFFFFFFF; a read of an unmapped offset returns 0xFFFFFFFF.
- R10: After reset, the liveness, operand/result, status and interrupt status registers are zero and the interrupt output is low.
- R11: Read data appears on the read-data port with its valid strobe one clock after the read request is sampled, and it reflects the register contents before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_bytes | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| irq | output | 1 | Level interrupt, high while any status bit is set |

## Verification
The completion of a factorial and a host write to the clear register at 0x64 can both land on the same clock edge. Both act on bit 0 of the interrupt status. The bench provokes this by loading operand 5 with the completion interrupt enabled. It counts the five edges the multiply loop needs, and it places a clear of bits 0 and 1 on the finishing edge. Bit 1 was set earlier through 0x60. The outcome is judged by reading 0x24, which must hold only bit 0, and by checking that the interrupt output stays high. A completion that lost to the clear, or a clear that was dropped, both show up as a wrong status value.

// File: rtl/fact_accel_pkg.sv
// Shared constants for the factorial accelerator: widths, register
// offsets and fixed values. Assumes byte offsets fit in ADDR_W bits.
package fact_accel_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int SIZE_W = 3;

    localparam logic [SIZE_W-1:0] FULL_BYTES = 3'd4;

    localparam logic [ADDR_W-1:0] OFF_IDENT  = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_LIVE   = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_VALUE  = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_ISTAT  = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_ISET   = 8'h60;
    localparam logic [ADDR_W-1:0] OFF_ICLR   = 8'h64;

    localparam logic [DATA_W-1:0] IDENT_WORD = 32'h0100_00ED;
    localparam int BUSY_BIT = 0;
    localparam int IEN_BIT  = 7;
    localparam int DONE_SRC = 0;
endpackage

// File: rtl/fact_engine.sv
// Sequential factorial engine. A start pulse while idle latches the
// operand and starts a loop of one multiply per clock, counting down to 1.
// value_o shows the operand while busy and the result after completion.
// Assumes start_i is only meaningful while idle; it is ignored when busy.
module fact_engine #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] operand_i,
    output logic         busy_o,
    output logic         fin_o,
    output logic [W-1:0] value_o
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] acc_q;
    logic [W-1:0] cnt_q;

    // Finish when the countdown has reached 1 (or started at 0).
    assign fin_o = busy_o && (cnt_q <= ONE);

    // Load, multiply down, and publish the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o  <= 1'b0;
            acc_q   <= '0;
            cnt_q   <= '0;
            value_o <= '0;
        end else if (!busy_o) begin
            if (start_i) begin
                busy_o  <= 1'b1;
                acc_q   <= ONE;
                cnt_q   <= operand_i;
                value_o <= operand_i;
            end
        end else if (fin_o) begin
            busy_o  <= 1'b0;
            value_o <= acc_q;
        end else begin
            acc_q <= acc_q * cnt_q;
            cnt_q <= cnt_q - ONE;
        end
    end

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !fin_o |=> busy_o && $stable(value_o));
    // R4
    fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |=> !busy_o);
endmodule

// File: rtl/fact_irq_ctrl.sv
// Interrupt status aggregation. Each cycle, the bits in clr_i are removed
// and then the bits in set_i are added, so a set beats a clear of the same
// bit. The line is high while any status bit is set.
module fact_irq_ctrl #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] status_o,
    output logic         irq_o
);
    // Apply the clear mask, then the set mask.
    always_ff @(posedge clk) begin
        if (!rst_n) status_o <= '0;
        else        status_o <= (status_o & ~clr_i) | set_i;
    end

    // Reduce the status word to one level line.
    assign irq_o = |status_o;

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((status_o & $past(set_i)) == $past(set_i)));
    // R7
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((status_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/fact_accel_top.sv
// Register-port top of the factorial accelerator. Decodes 4-byte accesses,
// holds the liveness and enable registers, and routes completion and
// host set/clear writes into the interrupt controller. Read data is
// registered: it is valid one cycle after the request.
module fact_accel_top
    import fact_accel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_bytes,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    logic              full_sz;
    logic              wr_ok;
    logic              rd_req;
    logic [DATA_W-1:0] live_q;
    logic              ien_q;
    logic              busy;
    logic              fin;
    logic [DATA_W-1:0] value;
    logic [DATA_W-1:0] istat;
    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] clr_vec;
    logic [DATA_W-1:0] status_word;
    logic [DATA_W-1:0] rd_mux;

    assign full_sz = (req_bytes == FULL_BYTES);
    assign wr_ok   = req_valid && req_write && full_sz;
    assign rd_req  = req_valid && !req_write;

    fact_engine #(.W(DATA_W)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (wr_ok && (req_addr == OFF_VALUE)),
        .operand_i(req_wdata),
        .busy_o   (busy),
        .fin_o    (fin),
        .value_o  (value)
    );

    // Gather interrupt sources: host OR-set plus enabled completion.
    always_comb begin
        set_vec = '0;
        if (wr_ok && (req_addr == OFF_ISET)) set_vec = req_wdata;
        if (fin && ien_q) set_vec[DONE_SRC] = 1'b1;
        clr_vec = (wr_ok && (req_addr == OFF_ICLR)) ? req_wdata : '0;
    end

    fact_irq_ctrl #(.W(DATA_W)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_vec),
        .clr_i   (clr_vec),
        .status_o(istat),
        .irq_o   (irq)
    );

    // Liveness and interrupt-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
            ien_q  <= 1'b0;
        end else if (wr_ok) begin
            if (req_addr == OFF_LIVE)   live_q <= ~req_wdata;
            if (req_addr == OFF_STATUS) ien_q  <= req_wdata[IEN_BIT];
        end
    end

    // Assemble the status word from busy and enable.
    always_comb begin
        status_word = '0;
        status_word[BUSY_BIT] = busy;
        status_word[IEN_BIT]  = ien_q;
    end

    // Select read data; narrow and unmapped reads give all ones.
    always_comb begin
        rd_mux = '1;
        if (full_sz) begin
            case (req_addr)
                OFF_IDENT:  rd_mux = IDENT_WORD;
                OFF_LIVE:   rd_mux = live_q;
                OFF_VALUE:  rd_mux = value;
                OFF_STATUS: rd_mux = status_word;
                OFF_ISTAT:  rd_mux = istat;
                default:    rd_mux = '1;
            endcase
        end
    end

    // Register the read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) rd_data <= rd_mux;
        end
    end

    // R1
    ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && full_sz && (req_addr == OFF_IDENT) |=> rd_valid && (rd_data == IDENT_WORD));
    // R2
    live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok && (req_addr == OFF_LIVE) |=> (live_q == ~$past(req_wdata)));
    // R5
    ien_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ok && (req_addr == OFF_STATUS)) |=> $stable(ien_q));
    // R9
    narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !full_sz |=> rd_valid && (rd_data == '1));
    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(set_vec) != '0));
endmodule

// File: tb/tb_fact_accel_top.sv
// Scoreboard bench: read tasks push expected words into a queue, and a
// monitor pops and compares them when the registered read data appears.
module tb_fact_accel_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [2:0]  req_bytes = 3'd4;
    logic [31:0] req_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fact_accel_top dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_bytes(req_bytes), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver tasks: called at a negedge, return at the next negedge.
    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic [2:0] b = 3'd4);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_bytes = b;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic [31:0] e, input string tag,
                          input logic [2:0] b = 3'd4);
        exp_q.push_back(e); tag_q.push_back(tag);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_bytes = b;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: compare each read response against the scoreboard (R11).
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rd_valid) begin
                if (exp_q.size() == 0) begin
                    check(rd_data, 32'hDEAD_BEEF, "R11 unexpected read");
                end else begin
                    check(rd_data, exp_q.pop_front(), tag_q.pop_front());
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check({31'b0, irq}, 32'h0, "R10 irq after reset");
        bus_rd(8'h04, 32'h0, "R10 live reset");
        bus_rd(8'h08, 32'h0, "R10 value reset");
        bus_rd(8'h20, 32'h0, "R10 status reset");
        bus_rd(8'h24, 32'h0, "R10 istat reset");
        // R1 identification
        bus_rd(8'h00, 32'h0100_00ED, "R1 ident");
        // R2 liveness
        bus_wr(8'h04, 32'h1234_5678);
        bus_rd(8'h04, 32'hEDCB_A987, "R2 complement");
        // R9 narrow accesses and unmapped offset
        bus_wr(8'h04, 32'h0, 3'd2);
        bus_rd(8'h04, 32'hEDCB_A987, "R9 narrow write ignored");
        bus_rd(8'h00, 32'hFFFF_FFFF, "R9 narrow read", 3'd1);
        bus_rd(8'h30, 32'hFFFF_FFFF, "R9 unmapped read");
        // R3/R4/R5 busy window for operand 5, enable clear
        bus_wr(8'h08, 32'd5);
        for (int i = 0; i < 5; i++) bus_rd(8'h20, 32'h1, "R4 busy window");
        bus_rd(8'h20, 32'h0, "R4 busy cleared");
        bus_rd(8'h08, 32'd120, "R4 5!");
        bus_rd(8'h24, 32'h0, "R6 no irq when disabled");
        // R4 operands 0, 1 and wrap modulo 2^32
        bus_wr(8'h08, 32'd0); idle(2);
        bus_rd(8'h08, 32'd1, "R4 0!");
        bus_wr(8'h08, 32'd1); idle(2);
        bus_rd(8'h08, 32'd1, "R4 1!");
        bus_wr(8'h08, 32'd13); idle(15);
        bus_rd(8'h08, 32'h7328_CC00, "R4 13! mod 2^32");
        // R3 write while busy ignored
        bus_wr(8'h08, 32'd12);
        bus_wr(8'h08, 32'd3);
        bus_rd(8'h08, 32'd12, "R3 operand held while busy");
        idle(14);
        bus_rd(8'h08, 32'h1C8C_FC00, "R3 12! unaffected");
        // R5 only bit 7 written
        bus_wr(8'h20, 32'hFFFF_FFFF);
        bus_rd(8'h20, 32'h80, "R5 enable only");
        // R7/R8 set and clear registers
        bus_wr(8'h60, 32'h0000_0102);
        bus_rd(8'h24, 32'h0000_0102, "R7 or-set");
        check({31'b0, irq}, 32'h1, "R8 irq high");
        bus_wr(8'h64, 32'h0000_0100);
        bus_rd(8'h24, 32'h0000_0002, "R7 clear mask");
        // R6/R7 completion colliding with a clear on the same edge
        bus_wr(8'h08, 32'd5);
        idle(4);
        bus_wr(8'h64, 32'h3);
        bus_rd(8'h24, 32'h1, "R7 set wins over clear");
        check({31'b0, irq}, 32'h1, "R8 irq held by completion");
        bus_wr(8'h64, 32'hFFFF_FFFF);
        bus_rd(8'h24, 32'h0, "R7 all cleared");
        check({31'b0, irq}, 32'h0, "R8 irq low");
        // R6 plain completion with enable
        bus_wr(8'h08, 32'd3); idle(4);
        bus_rd(8'h24, 32'h1, "R6 completion irq");
        check({31'b0, irq}, 32'h1, "R8 irq from completion");
        idle(2);
        check(exp_q.size(), 32'h0, "R11 all reads answered");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule